// File: doc/BRIEF.md
# Rung-Edge Up/Down Event Counter

This block counts events the way a relay-logic counter instruction does. Two rung inputs, one for counting up and one for counting down, are sampled on the system clock. Only a false-to-true change of a rung moves the count. The accumulated count is a signed two's-complement word. It runs freely past the preset in both directions. It wraps at the signed limits, and each wrap raises a flag that stays set.

A preset word is loaded through a strobe. A done flag reports whether the count has reached the preset, compared as signed values. A synchronous clear input zeroes the count and drops every status flag. The level of each rung, as seen by the counter, is brought out as an enable flag. Rung inputs that come from another clock domain can be passed through an optional synchronizer chain, chosen by a parameter.

Top module: `evc_counter`

## Requirements
- R1: With no clear and no down edge, a cycle in which `up_rung` is sampled high after being sampled low adds one to `acc` at that same clock edge. Holding `up_rung` high for more cycles adds nothing further.
- R2: With no clear and no up edge, a low-to-high change of `dn_rung` subtracts one from `acc` at that edge. A held level subtracts nothing further.
- R3: An up count from `acc` = 32767 (0x7FFF) gives `acc` = -32768 (0x8000) and sets `ovf`. `ovf` then stays 1 until a clear or a reset.
- R4: A down count from `acc` = -32768 (0x8000) gives `acc` = 32767 (0x7FFF) and sets `unf`. `unf` then stays 1 until a clear or a reset.
- R5: The count does not stop at the preset. Up edges after `acc` has reached the preset keep incrementing it.
- R6: After each clock edge without clear, `done` is 1 exactly when signed `acc` >= signed preset, with both values taken after that edge.
- R7: `clr` high at an edge sets `acc` to 0 and `ovf`, `unf` and `done` to 0. It takes priority over any rung edge in that cycle.
- R8: When up and down edges fall in the same cycle, `acc` keeps its value.
- R9: `up_en` and `dn_en` show the level of `up_rung` and `dn_rung` as sampled at the most recent clock edge.
- R10: `pre_ld` high at an edge loads `pre_val` as the new signed preset. `done` reflects the new preset at that same edge. Negative presets compare as negative values.
- R11: While `rst_n` is low, `acc` = 0, `done` = 0, `ovf` = 0, `unf` = 0, `up_en` = 0, `dn_en` = 0, and the preset takes the value `PRESET_INIT` (0 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous counter clear |
| up_rung | input | 1 | Count-up rung level |
| dn_rung | input | 1 | Count-down rung level |
| pre_ld | input | 1 | Preset load strobe |
| pre_val | input | W (16) | New preset, signed |
| acc | output | W (16) | Accumulated count, signed |
| done | output | 1 | Count has reached the preset |
| up_en | output | 1 | Sampled up-rung level |
| dn_en | output | 1 | Sampled down-rung level |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |

## Verification
The bench walks the count all the way up to +32767 and takes one more step. A design that saturated, or that compared unsigned at the top, would stick at 0x7FFF or leave `ovf` low. It then steps down across -32768, where a wrong wrap would leave the count at 0x8000 or miss the underflow. Rungs are held high for several cycles, so a design that counted levels instead of edges would run away. Rising edges on both rungs in the same cycle would move a design with an up- or down-priority scheme. A negative preset with a positive count would show a sign-blind comparator through a wrong `done`. A clear that arrives together with a rung edge checks that the clear wins.

// File: rtl/evc_pkg.sv
package evc_pkg;

   // Net action of one cycle on the accumulator
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_INC  = 2'd1,
      STEP_DEC  = 2'd2
   } evc_step_e;

   // Largest supported synchronizer depth
   localparam int unsigned EVC_MAX_SYNC = 4;

endpackage

// File: rtl/evc_edge.sv
// Rung sampler: optional synchronizer chain, previous-level register, rise pulse.
module evc_edge #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rung_i,
   output logic level_o,
   output logic rise_o
);

   logic lvl;
   logic prev_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign lvl = rung_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh_q;
         for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) sh_q[0] <= 1'b0;
                  else        sh_q[0] <= rung_i;
               end
            end else begin : g_next
               always_ff @(posedge clk or negedge rst_n) begin
                  if (!rst_n) sh_q[i] <= 1'b0;
                  else        sh_q[i] <= sh_q[i-1];
               end
            end
         end
         assign lvl = sh_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise_o  = lvl & ~prev_q;
   assign level_o = prev_q;

endmodule

// File: rtl/evc_accum.sv
// Signed accumulator with wrap at the signed limits and sticky wrap flags.
module evc_accum
   import evc_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          rise_up,
   input  logic          rise_dn,
   output logic [W-1:0]  acc_o,
   output logic [W-1:0]  acc_nxt_o,
   output logic          ovf_o,
   output logic          unf_o
);

   localparam logic [W-1:0] ACC_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] ACC_MIN = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

   evc_step_e    step;
   logic [W-1:0] acc_q, acc_d;
   logic         ovf_q, ovf_d, unf_q, unf_d;

   // Opposing edges in one cycle cancel
   always_comb begin
      unique case ({rise_up, rise_dn})
         2'b10:   step = STEP_INC;
         2'b01:   step = STEP_DEC;
         default: step = STEP_HOLD;
      endcase
   end

   always_comb begin
      acc_d = acc_q;
      ovf_d = ovf_q;
      unf_d = unf_q;
      if (clr) begin
         acc_d = '0;
         ovf_d = 1'b0;
         unf_d = 1'b0;
      end else begin
         unique case (step)
            STEP_INC: begin
               acc_d = acc_q + ONE;
               if (acc_q == ACC_MAX) ovf_d = 1'b1;
            end
            STEP_DEC: begin
               acc_d = acc_q - ONE;
               if (acc_q == ACC_MIN) unf_d = 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
         unf_q <= 1'b0;
      end else begin
         acc_q <= acc_d;
         ovf_q <= ovf_d;
         unf_q <= unf_d;
      end
   end

   assign acc_o     = acc_q;
   assign acc_nxt_o = acc_d;
   assign ovf_o     = ovf_q;
   assign unf_o     = unf_q;

endmodule

// File: rtl/evc_done.sv
// Preset register and registered signed reach-compare.
module evc_done #(
   parameter int unsigned    W           = 16,
   parameter logic [W-1:0]   PRESET_INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          pre_ld,
   input  logic [W-1:0]  pre_val,
   input  logic [W-1:0]  acc_nxt,
   output logic [W-1:0]  pre_o,
   output logic          done_o
);

   logic [W-1:0] pre_q, pre_d;
   logic         done_q, done_d;

   assign pre_d  = pre_ld ? pre_val : pre_q;
   assign done_d = clr ? 1'b0 : ($signed(acc_nxt) >= $signed(pre_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= PRESET_INIT;
         done_q <= 1'b0;
      end else begin
         pre_q  <= pre_d;
         done_q <= done_d;
      end
   end

   assign pre_o  = pre_q;
   assign done_o = done_q;

endmodule

// File: rtl/evc_counter.sv
module evc_counter #(
   parameter int unsigned   W           = 16,
   parameter int unsigned   SYNC_STAGES = 0,
   parameter logic [W-1:0]  PRESET_INIT = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          up_rung,
   input  logic          dn_rung,
   input  logic          pre_ld,
   input  logic [W-1:0]  pre_val,
   output logic [W-1:0]  acc,
   output logic          done,
   output logic          up_en,
   output logic          dn_en,
   output logic          ovf,
   output logic          unf
);

   generate
      if (W < 2) begin : g_bad_w
         $error("evc_counter: W must be at least 2");
      end
      if (SYNC_STAGES > evc_pkg::EVC_MAX_SYNC) begin : g_bad_sync
         $error("evc_counter: SYNC_STAGES exceeds the supported depth");
      end
   endgenerate

   logic         rise_up, rise_dn;
   logic [W-1:0] acc_nxt;
   logic [W-1:0] pre_q;

   evc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_up (
      .clk     (clk),
      .rst_n   (rst_n),
      .rung_i  (up_rung),
      .level_o (up_en),
      .rise_o  (rise_up)
   );

   evc_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge_dn (
      .clk     (clk),
      .rst_n   (rst_n),
      .rung_i  (dn_rung),
      .level_o (dn_en),
      .rise_o  (rise_dn)
   );

   evc_accum #(.W(W)) u_accum (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (clr),
      .rise_up   (rise_up),
      .rise_dn   (rise_dn),
      .acc_o     (acc),
      .acc_nxt_o (acc_nxt),
      .ovf_o     (ovf),
      .unf_o     (unf)
   );

   evc_done #(.W(W), .PRESET_INIT(PRESET_INIT)) u_done (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .pre_ld  (pre_ld),
      .pre_val (pre_val),
      .acc_nxt (acc_nxt),
      .pre_o   (pre_q),
      .done_o  (done)
   );

endmodule

// File: rtl/evc_counter_chk.sv
module evc_counter_chk #(
   parameter int unsigned W           = 16,
   parameter int unsigned SYNC_STAGES = 0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic          up_rung,
   input logic          dn_rung,
   input logic          pre_ld,
   input logic [W-1:0]  acc,
   input logic          done,
   input logic          up_en,
   input logic          dn_en,
   input logic          ovf,
   input logic          unf,
   input logic [W-1:0]  pre_q
);

   localparam logic [W-1:0] CHK_MAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] CHK_MIN = {1'b1, {(W-1){1'b0}}};

   // Sticky wrap flags
   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);
   p_unf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (unf && !clr) |=> unf);

   // Clear result
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0 && !ovf && !unf && !done));

   // Reach flag against the preset register
   p_done_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (done == ($signed(acc) >= $signed(pre_q))));

   generate
      if (SYNC_STAGES == 0) begin : g_edge_props
         p_up_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && up_rung && !up_en && !(dn_rung && !dn_en))
            |=> (acc == W'($past(acc) + 1'b1)));
         p_dn_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && dn_rung && !dn_en && !(up_rung && !up_en))
            |=> (acc == W'($past(acc) - 1'b1)));
         p_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && up_rung && !up_en && dn_rung && !dn_en) |=> $stable(acc));
         p_level_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && !(up_rung && !up_en) && !(dn_rung && !dn_en)) |=> $stable(acc));
         p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && up_rung && !up_en && !(dn_rung && !dn_en) && acc == CHK_MAX)
            |=> (acc == CHK_MIN && ovf));
         p_wrap_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && dn_rung && !dn_en && !(up_rung && !up_en) && acc == CHK_MIN)
            |=> (acc == CHK_MAX && unf));
         p_en_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (up_en == $past(up_rung) && dn_en == $past(dn_rung)));
      end
   endgenerate

   // Preset load reaches the register
   p_preload_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !pre_ld |=> $stable(pre_q));

endmodule

bind evc_counter evc_counter_chk #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (clr),
   .up_rung (up_rung),
   .dn_rung (dn_rung),
   .pre_ld  (pre_ld),
   .acc     (acc),
   .done    (done),
   .up_en   (up_en),
   .dn_en   (dn_en),
   .ovf     (ovf),
   .unf     (unf),
   .pre_q   (pre_q)
);

// File: tb/evc_counter_tb.sv
`timescale 1ns/1ps
module evc_counter_tb;

   localparam int W    = 16;
   localparam int MAXV = (2 ** (W - 1)) - 1;
   localparam int MINV = -(2 ** (W - 1));

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clr = 1'b0;
   logic          up_rung = 1'b0;
   logic          dn_rung = 1'b0;
   logic          pre_ld = 1'b0;
   logic [W-1:0]  pre_val = '0;
   logic [W-1:0]  acc;
   logic          done, up_en, dn_en, ovf, unf;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   evc_counter u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .up_rung(up_rung), .dn_rung(dn_rung),
      .pre_ld(pre_ld), .pre_val(pre_val), .acc(acc), .done(done),
      .up_en(up_en), .dn_en(dn_en), .ovf(ovf), .unf(unf)
   );

   // Behavioural reference
   int m_acc, m_pre;
   bit m_done, m_ovf, m_unf, m_upp, m_dnp;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_acc = 0; m_pre = 0; m_done = 0; m_ovf = 0; m_unf = 0; m_upp = 0; m_dnp = 0;
      end else begin
         bit ru, rd;
         ru = up_rung && !m_upp;
         rd = dn_rung && !m_dnp;
         if (clr) begin
            m_acc = 0; m_ovf = 0; m_unf = 0;
         end else if (ru && !rd) begin
            if (m_acc == MAXV) begin m_acc = MINV; m_ovf = 1; end
            else m_acc = m_acc + 1;
         end else if (rd && !ru) begin
            if (m_acc == MINV) begin m_acc = MAXV; m_unf = 1; end
            else m_acc = m_acc - 1;
         end
         if (pre_ld) m_pre = $signed(pre_val);
         m_done = clr ? 1'b0 : (m_acc >= m_pre);
         m_upp = up_rung;
         m_dnp = dn_rung;
      end
   end

   task automatic cmp(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   // Compare against the model on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         cmp("R1 acc", $signed(acc), m_acc);
         cmp("R6 done", int'(done), int'(m_done));
         cmp("R3 ovf", int'(ovf), int'(m_ovf));
         cmp("R4 unf", int'(unf), int'(m_unf));
         cmp("R9 up_en", int'(up_en), int'(m_upp));
         cmp("R9 dn_en", int'(dn_en), int'(m_dnp));
      end
   end

   task automatic pulse_up(input int n, input int hold);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) up_rung = 1'b1;
         repeat (hold) @(negedge clk);
         up_rung = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic pulse_dn(input int n, input int hold);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) dn_rung = 1'b1;
         repeat (hold) @(negedge clk);
         dn_rung = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic load_pre(input int v);
      @(negedge clk) pre_ld = 1'b1; pre_val = W'(v);
      @(negedge clk) pre_ld = 1'b0;
   endtask

   task automatic do_clr();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
   endtask

   initial begin
      #1;
      // R11: reset state
      cmp("R11 acc", int'(acc), 0);
      cmp("R11 done", int'(done), 0);
      cmp("R11 ovf", int'(ovf), 0);
      cmp("R11 unf", int'(unf), 0);
      cmp("R11 up_en", int'(up_en), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: held levels count once per edge
      pulse_up(5, 3);
      cmp("R1 five edges", $signed(acc), 5);

      // R9: level shows after one edge
      @(negedge clk) up_rung = 1'b1;
      @(negedge clk);
      cmp("R9 up level", int'(up_en), 1);
      up_rung = 1'b0;
      @(negedge clk);
      cmp("R1 one more", $signed(acc), 6);

      // R2: down edges
      pulse_dn(4, 2);
      cmp("R2 down four", $signed(acc), 2);

      // R10/R6: preset 4, count below then past
      load_pre(4);
      cmp("R10 done below preset", int'(done), 0);
      pulse_up(2, 1);
      cmp("R6 done at preset", int'(done), 1);
      pulse_up(4, 1);
      cmp("R5 past preset", $signed(acc), 8);

      // R8: simultaneous rises cancel
      @(negedge clk) begin up_rung = 1'b1; dn_rung = 1'b1; end
      @(negedge clk);
      cmp("R8 cancel", $signed(acc), 8);
      up_rung = 1'b0; dn_rung = 1'b0;
      @(negedge clk);

      // R7: clear beats an up edge
      @(negedge clk) begin clr = 1'b1; up_rung = 1'b1; end
      @(negedge clk);
      cmp("R7 clear acc", $signed(acc), 0);
      cmp("R7 clear done", int'(done), 0);
      clr = 1'b0; up_rung = 1'b0;
      @(negedge clk);

      // R10: negative preset, zero count reaches it
      load_pre(-5);
      cmp("R10 negative preset done", int'(done), 1);

      // R3: walk to the top and wrap
      pulse_up(MAXV, 1);
      cmp("R3 at max", $signed(acc), MAXV);
      cmp("R3 no ovf yet", int'(ovf), 0);
      pulse_up(1, 1);
      cmp("R3 wrapped", $signed(acc), MINV);
      cmp("R3 ovf set", int'(ovf), 1);
      cmp("R10 min below -5", int'(done), 0);

      // R4: below the bottom
      pulse_dn(1, 1);
      cmp("R4 wrapped", $signed(acc), MAXV);
      cmp("R4 unf set", int'(unf), 1);
      pulse_up(3, 2);
      cmp("R3 ovf sticky", int'(ovf), 1);
      cmp("R4 unf sticky", int'(unf), 1);
      do_clr();
      cmp("R7 flags cleared", int'(ovf) + int'(unf), 0);

      // Mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         up_rung = $urandom_range(0, 1) != 0;
         dn_rung = $urandom_range(0, 2) == 0;
         clr     = $urandom_range(0, 60) == 0;
         pre_ld  = $urandom_range(0, 20) == 0;
         pre_val = W'($urandom_range(0, 40)) - W'(20);
      end
      @(negedge clk) begin up_rung = 0; dn_rung = 0; clr = 0; pre_ld = 0; end
      repeat (2) @(negedge clk);
      summary();
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
   end

endmodule